// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This block is a watchdog that runs from its own low-speed clock, separate from the bus clock that software uses to program it. A down-counter is stepped by a power-of-two prescaler. When the counter runs out, the block raises a reset request for the system and then starts counting again from the reload value. Software must refresh the counter before it runs out.

All control goes through 32-bit key words written to one register. One key opens the prescaler and reload registers for writing. Any other key word closes them again. A second key starts the watchdog, and nothing short of a system reset stops it once it is running. A third key refreshes the counter.

A new prescaler or reload value is carried into the slow clock domain by a toggle handshake. Until it arrives, a busy flag is shown in the status register, and further writes to that register are ignored.

Top module: `keyed_wdog`

## Requirements
- R1: After rst_n is released, the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, rst_req is low and the watchdog is not running.
- R2: Write protection works as follows:
  - Writing exactly 0x00005555 to the key register (offset 0x00) opens the prescaler and reload registers for writing.
  - Writing any other value to the key register closes them.
  - While they are closed, writes to the prescaler and reload registers leave their read-back values unchanged.
- R3: Writing exactly 0x0000CCCC to the key register starts the watchdog. Before that write, rst_req never asserts, whatever the configuration.
- R4: While the watchdog is running with settled configuration, consecutive rst_req pulses are exactly (reload+1) × 4 × 2^PR slow-clock cycles apart. Each pulse is one slow-clock cycle wide, and the counter restarts from the reload value after each pulse.
- R5: Writing exactly 0x0000AAAA to the key register reloads the down-counter and restarts the prescaler phase. Refreshes issued more often than the timeout period keep rst_req low.
- R6: Once started, the watchdog keeps producing rst_req pulses after any sequence of key writes. Only rst_n stops it.
- R7: The busy flags behave as follows:
  - Status bit 0 is set from the cycle after an accepted prescaler write until the new value is in use in the slow domain.
  - Status bit 1 does the same for the reload register.
  - Both flags read 0 afterwards.
  - A write to a register whose busy flag is set is ignored.
- R8: Writes to the prescaler register saturate at code log2(MAX_RATIO/4), which is 6 for MAX_RATIO = 256.
- R9: The register offsets are:
  - prescaler at 0x04
  - reload at 0x08
  - status at 0x0C
  - window at 0x10

  The key register and the window register read 0, and any unmapped offset reads 0.
- R10: A reload write above 0xFFF stores 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register interface clock |
| slow_clk | input | 1 | Low-speed watchdog counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| rst_req | output | 1 | One slow-cycle reset request pulse (slow domain) |

## Verification
The bench builds the block with the following parameters:
- MAX_RATIO = 256, so the prescaler code saturates at 6.
- DATA_W = 32.
- SYNC_STAGES = 2.

It programs small reload values (3 and then 2) with prescaler codes 0 and 1. The resulting timeouts of 16 and 24 slow cycles allow many expiries, refresh runs and period measurements to fit in a short run.

The slow clock runs eight times slower than the bus clock. This keeps each busy flag set long enough that reads just after a write observe it, along with a second, ignored write.

// File: rtl/kw_pkg.sv
package kw_pkg;
   // Register byte offsets (bus side decode)
   localparam int unsigned OFF_KEY  = 32'h00;
   localparam int unsigned OFF_DIV  = 32'h04;
   localparam int unsigned OFF_RLD  = 32'h08;
   localparam int unsigned OFF_STAT = 32'h0C;
   localparam int unsigned OFF_WIN  = 32'h10;

   // Status bit positions
   localparam int unsigned STAT_DIV_BIT = 0;
   localparam int unsigned STAT_RLD_BIT = 1;

   // Key words
   localparam logic [31:0] KEY_OPEN_W = 32'h0000_5555;
   localparam logic [31:0] KEY_GO_W   = 32'h0000_CCCC;
   localparam logic [31:0] KEY_FEED_W = 32'h0000_AAAA;

   typedef enum logic [1:0] {
      KEY_OTHER,
      KEY_OPEN,
      KEY_GO,
      KEY_FEED
   } key_cmd_e;

   function automatic key_cmd_e decode_key(input logic [31:0] w);
      key_cmd_e c;
      if (w == KEY_OPEN_W)      c = KEY_OPEN;
      else if (w == KEY_GO_W)   c = KEY_GO;
      else if (w == KEY_FEED_W) c = KEY_FEED;
      else                      c = KEY_OTHER;
      return c;
   endfunction
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   initial begin
      assert_sync_depth: assert (STAGES >= 2)
         else $error("kw_sync needs at least two stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[0] <= 1'b0;
            else        sr[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else        sr[i] <= sr[i-1];
         end
      end
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/kw_xfer.sv
module kw_xfer #(
   parameter int unsigned W       = 8,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter int unsigned STAGES  = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic         src_req,
   input  logic [W-1:0] src_data,
   output logic         src_busy,
   output logic         dst_upd,
   output logic [W-1:0] dst_data
);
   logic req_tgl;
   logic ack_s;
   logic req_s;
   logic seen;

   // Source side: flip a toggle per accepted request
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)                    req_tgl <= 1'b0;
      else if (src_req && !src_busy) req_tgl <= ~req_tgl;
   end

   kw_sync #(.STAGES(STAGES)) u_req_sync (
      .clk   (dst_clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   // Destination side: take data when the toggle arrives
   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         dst_data <= RST_VAL;
         dst_upd  <= 1'b0;
      end else if (req_s != seen) begin
         seen     <= req_s;
         dst_data <= src_data;
         dst_upd  <= 1'b1;
      end else begin
         dst_upd  <= 1'b0;
      end
   end

   kw_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (seen),
      .q     (ack_s)
   );

   assign src_busy = req_tgl ^ ack_s;

   // R7: a busy flag only ever rises because of a request
   assert_busy_origin_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(src_busy) |-> $past(src_req));
endmodule

// File: rtl/kw_regs.sv
module kw_regs
   import kw_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned PR_W   = 3,
   parameter int unsigned PR_MAX = 6,
   parameter int unsigned RLD_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              pr_busy,
   input  logic              rld_busy,
   output logic [PR_W-1:0]   pr_q,
   output logic              pr_req,
   output logic [RLD_W-1:0]  rld_q,
   output logic              rld_req,
   output logic              started,
   output logic              kick_tgl
);
   localparam logic [RLD_W-1:0] RLD_ALL = '1;
   localparam logic [PR_W-1:0]  PR_TOP  = PR_W'(PR_MAX);

   logic [31:0]      wd32;
   logic [31:0]      ad32;
   logic [31:0]      rd32;
   logic             unlocked;
   logic             wr_key;
   logic             wr_pr;
   logic             wr_rld;
   key_cmd_e         cmd;
   logic [PR_W-1:0]  pr_next;
   logic [RLD_W-1:0] rld_next;

   assign wd32   = 32'(wdata);
   assign ad32   = 32'(addr);
   assign wr_key = wr && (ad32 == OFF_KEY);
   assign wr_pr  = wr && (ad32 == OFF_DIV);
   assign wr_rld = wr && (ad32 == OFF_RLD);
   assign cmd    = decode_key(wd32);

   assign pr_req  = wr_pr  && unlocked && !pr_busy;
   assign rld_req = wr_rld && unlocked && !rld_busy;

   // Saturate the incoming field values
   assign pr_next  = (wd32 > 32'(PR_MAX))  ? PR_TOP  : wd32[PR_W-1:0];
   assign rld_next = (wd32 > 32'(RLD_ALL)) ? RLD_ALL : wd32[RLD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         started  <= 1'b0;
         kick_tgl <= 1'b0;
      end else if (wr_key) begin
         unlocked <= (cmd == KEY_OPEN);
         if (cmd == KEY_GO)   started  <= 1'b1;
         if (cmd == KEY_FEED) kick_tgl <= ~kick_tgl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pr_q <= '0;
      else if (pr_req) pr_q <= pr_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rld_q <= RLD_ALL;
      else if (rld_req) rld_q <= rld_next;
   end

   always_comb begin
      rd32 = '0;
      case (ad32)
         OFF_DIV:  rd32 = 32'(pr_q);
         OFF_RLD:  rd32 = 32'(rld_q);
         OFF_STAT: begin
            rd32[STAT_DIV_BIT] = pr_busy;
            rd32[STAT_RLD_BIT] = rld_busy;
         end
         default:  rd32 = '0;
      endcase
   end

   assign rdata = rd32[DATA_W-1:0];

   // R2: a closed register keeps its value
   assert_locked_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pr && !unlocked) |=> $stable(pr_q));
   // R6: once started the watchdog never stops
   assert_no_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      started |=> started);
   // R8: prescaler code never exceeds its ceiling
   assert_div_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pr_q <= PR_TOP);
   // R7: a write during busy leaves the reload value alone
   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rld && rld_busy) |=> $stable(rld_q));
endmodule

// File: rtl/kw_core.sv
module kw_core #(
   parameter int unsigned PR_W   = 3,
   parameter int unsigned RLD_W  = 12,
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_async,
   input  logic             kick_async,
   input  logic [PR_W-1:0]  pr,
   input  logic [RLD_W-1:0] rld,
   input  logic             cfg_upd,
   output logic             rst_req
);
   logic             run_s;
   logic             run_d;
   logic             kick_s;
   logic             kick_d;
   logic             go_edge;
   logic             kick_edge;
   logic [DIV_W-1:0] div;
   logic [DIV_W-1:0] lim;
   logic [RLD_W-1:0] cnt;

   kw_sync #(.STAGES(STAGES)) u_run_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (run_async),
      .q     (run_s)
   );

   kw_sync #(.STAGES(STAGES)) u_kick_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (kick_async),
      .q     (kick_s)
   );

   assign go_edge   = run_s & ~run_d;
   assign kick_edge = kick_s ^ kick_d;
   // ratio - 1 = low (pr + 2) bits all ones
   assign lim = ~({DIV_W{1'b1}} << (32'(pr) + 32'd2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_d   <= 1'b0;
         kick_d  <= 1'b0;
         div     <= '0;
         cnt     <= '1;
         rst_req <= 1'b0;
      end else begin
         run_d   <= run_s;
         kick_d  <= kick_s;
         rst_req <= 1'b0;
         if (go_edge || kick_edge) begin
            div <= '0;
            cnt <= rld;
         end else if (cfg_upd) begin
            div <= '0;
         end else if (run_s) begin
            if (div == lim) begin
               div <= '0;
               if (cnt == '0) begin
                  rst_req <= 1'b1;
                  cnt     <= rld;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end else begin
               div <= div + 1'b1;
            end
         end
      end
   end

   // R4: reset request is a single-cycle pulse
   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R3: no request while the watchdog is idle
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_d |-> !rst_req);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
   parameter int unsigned MAX_RATIO   = 256,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              slow_clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req
);
   localparam int unsigned DIV_W  = $clog2(MAX_RATIO);
   localparam int unsigned PR_MAX = DIV_W - 2;
   localparam int unsigned PR_W   = $clog2(PR_MAX + 1);
   localparam int unsigned RLD_W  = 12;

   initial begin
      assert_ratio_cfg_R8: assert ((MAX_RATIO == 256) || (MAX_RATIO == 1024))
         else $error("MAX_RATIO must be 256 or 1024");
      assert_data_cfg_R9: assert ((DATA_W >= 16) && (DATA_W <= 32))
         else $error("DATA_W out of range");
      assert_addr_cfg_R9: assert (ADDR_W >= 5)
         else $error("ADDR_W too small for the register map");
   end

   logic [PR_W-1:0]  pr_q;
   logic [PR_W-1:0]  pr_s;
   logic             pr_req;
   logic             pr_busy;
   logic             pr_upd;
   logic [RLD_W-1:0] rld_q;
   logic [RLD_W-1:0] rld_s;
   logic             rld_req;
   logic             rld_busy;
   logic             rld_upd;
   logic             started;
   logic             kick_tgl;

   kw_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .PR_W   (PR_W),
      .PR_MAX (PR_MAX),
      .RLD_W  (RLD_W)
   ) u_regs (
      .clk      (bus_clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .pr_busy  (pr_busy),
      .rld_busy (rld_busy),
      .pr_q     (pr_q),
      .pr_req   (pr_req),
      .rld_q    (rld_q),
      .rld_req  (rld_req),
      .started  (started),
      .kick_tgl (kick_tgl)
   );

   kw_xfer #(
      .W       (PR_W),
      .RST_VAL ('0),
      .STAGES  (SYNC_STAGES)
   ) u_pr_xfer (
      .src_clk  (bus_clk),
      .dst_clk  (slow_clk),
      .rst_n    (rst_n),
      .src_req  (pr_req),
      .src_data (pr_q),
      .src_busy (pr_busy),
      .dst_upd  (pr_upd),
      .dst_data (pr_s)
   );

   kw_xfer #(
      .W       (RLD_W),
      .RST_VAL ({RLD_W{1'b1}}),
      .STAGES  (SYNC_STAGES)
   ) u_rld_xfer (
      .src_clk  (bus_clk),
      .dst_clk  (slow_clk),
      .rst_n    (rst_n),
      .src_req  (rld_req),
      .src_data (rld_q),
      .src_busy (rld_busy),
      .dst_upd  (rld_upd),
      .dst_data (rld_s)
   );

   kw_core #(
      .PR_W   (PR_W),
      .RLD_W  (RLD_W),
      .DIV_W  (DIV_W),
      .STAGES (SYNC_STAGES)
   ) u_core (
      .clk        (slow_clk),
      .rst_n      (rst_n),
      .run_async  (started),
      .kick_async (kick_tgl),
      .pr         (pr_s),
      .rld        (rld_s),
      .cfg_upd    (pr_upd | rld_upd),
      .rst_req    (rst_req)
   );
endmodule

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
   localparam int unsigned BUS_HALF  = 2500;   // 200 MHz in ps
   localparam int unsigned SLOW_HALF = 20000;  // 25 MHz in ps

   logic        bus_clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int checks = 0;
   int failures = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;
   bit mon_rd = 1'b0;

   int unsigned exp_val[$];
   string       exp_tag[$];

   always #(BUS_HALF)  bus_clk  = ~bus_clk;
   always #(SLOW_HALF) slow_clk = ~slow_clk;

   keyed_wdog #(
      .MAX_RATIO   (256),
      .DATA_W      (32),
      .ADDR_W      (5),
      .SYNC_STAGES (2)
   ) dut_i (
      .bus_clk   (bus_clk),
      .slow_clk  (slow_clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rst_req   (rst_req)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read values as the design returns them
   always @(negedge bus_clk) begin
      if (mon_rd) begin
         if (exp_val.size() == 0) begin
            check(1'b0, "scoreboard-empty", int'(bus_rdata), -1);
         end else begin
            automatic int unsigned e = exp_val.pop_front();
            automatic string t = exp_tag.pop_front();
            check(bus_rdata == e, t, int'(bus_rdata), int'(e));
         end
      end
   end

   always @(posedge slow_clk) if (rst_req) pulse_cnt++;

   task automatic bus_write(input int unsigned a, input int unsigned d);
      @(posedge bus_clk); #1;
      bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge bus_clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int unsigned a, input int unsigned e, input string t);
      @(posedge bus_clk); #1;
      bus_addr = 5'(a); mon_rd = 1'b1;
      exp_val.push_back(e); exp_tag.push_back(t);
      @(posedge bus_clk); #1;
      mon_rd = 1'b0;
   endtask

   task automatic wait_slow(input int n);
      repeat (n) @(posedge slow_clk);
      #1;
   endtask

   task automatic wait_pulse();
      do begin
         @(posedge slow_clk); #1;
      end while (!rst_req);
   endtask

   // Measure the distance between two pulses, then check the pulse width
   task automatic measure(input int exp, input string t);
      int n;
      wait_pulse();
      n = 0;
      do begin
         @(posedge slow_clk); #1;
         n++;
      end while (!rst_req);
      check(n == exp, t, n, exp);
      @(posedge slow_clk); #1;
      check(rst_req == 1'b0, "R4 pulse one cycle wide", int'(rst_req), 0);
   endtask

   initial begin
      #(500_000_000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int snap;
      repeat (4) @(posedge bus_clk);
      #1 rst_n = 1'b1;
      wait_slow(2);

      // Reset state and register map
      check(rst_req == 1'b0, "R1 rst_req low after reset", int'(rst_req), 0);
      bus_read(32'h04, 0,      "R1 prescaler reset value");
      bus_read(32'h08, 32'hFFF, "R1 reload reset value");
      bus_read(32'h0C, 0,      "R1 status reset value");
      bus_read(32'h00, 0,      "R9 key reads zero");
      bus_read(32'h10, 0,      "R9 window reads zero");
      bus_read(32'h18, 0,      "R9 unmapped reads zero");

      // Locked writes ignored
      bus_write(32'h04, 3);
      bus_read(32'h04, 0, "R2 locked prescaler write ignored");
      bus_write(32'h08, 5);
      bus_read(32'h08, 32'hFFF, "R2 locked reload write ignored");

      // Unlock, saturation, busy flags
      bus_write(32'h00, 32'h5555);
      bus_write(32'h04, 7);
      bus_read(32'h0C, 1, "R7 prescaler busy after write");
      bus_read(32'h04, 6, "R8 prescaler saturates at 6");
      wait_slow(20);
      bus_read(32'h0C, 0, "R7 prescaler busy cleared");
      bus_write(32'h04, 0);
      bus_write(32'h08, 32'h1003);
      bus_read(32'h08, 32'hFFF, "R10 reload saturates");
      wait_slow(20);
      bus_write(32'h08, 3);
      bus_write(32'h08, 7);
      bus_read(32'h0C, 2, "R7 reload busy after write");
      bus_read(32'h08, 3, "R7 write during busy ignored");
      wait_slow(20);
      bus_read(32'h0C, 0, "R7 both busy flags cleared");

      // Relock by foreign key
      bus_write(32'h00, 32'h1234);
      bus_write(32'h08, 9);
      bus_read(32'h08, 3, "R2 foreign key relocks");

      // Not started: no request
      snap = pulse_cnt;
      wait_slow(60);
      check(pulse_cnt == snap, "R3 no request before start", pulse_cnt - snap, 0);

      // Start and measure period (3+1)*4
      bus_write(32'h00, 32'hCCCC);
      measure(16, "R4 period reload 3 code 0");

      // Refresh keeps it quiet
      snap = pulse_cnt;
      for (int i = 0; i < 15; i++) begin
         bus_write(32'h00, 32'hAAAA);
         wait_slow(8);
      end
      check(pulse_cnt == snap, "R5 refresh holds off request", pulse_cnt - snap, 0);

      // New configuration while running: (2+1)*8
      bus_write(32'h00, 32'h5555);
      bus_write(32'h04, 1);
      bus_write(32'h08, 2);
      wait_slow(20);
      bus_read(32'h0C, 0, "R7 busy cleared while running");
      measure(24, "R4 period reload 2 code 1");

      // Attempts to stop
      bus_write(32'h00, 32'h0000);
      bus_write(32'h00, 32'h1234);
      bus_write(32'h00, 32'h5555);
      bus_write(32'h00, 32'h0000);
      snap = pulse_cnt;
      wait_slow(120);
      check((pulse_cnt - snap) >= 4, "R6 key writes cannot stop", pulse_cnt - snap, 5);

      // Only reset stops it
      @(posedge bus_clk); #1 rst_n = 1'b0;
      wait_slow(2);
      #1 rst_n = 1'b1;
      wait_slow(2);
      snap = pulse_cnt;
      wait_slow(120);
      check(pulse_cnt == snap, "R6 reset stops watchdog", pulse_cnt - snap, 0);
      bus_read(32'h04, 0,      "R1 prescaler after second reset");
      bus_read(32'h08, 32'hFFF, "R1 reload after second reset");

      wait_slow(2);
      check(exp_val.size() == 0, "scoreboard drained", exp_val.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule